// File: doc/BRIEF.md
# Unaligned Partial-Word Store Aligner

This combinational datapath prepares one memory write for a left or right partial store. Such stores are used in pairs so that software can write a word or a doubleword that starts at an unaligned address. The block receives the effective address, the access size, the left/right choice, three endianness controls and the source register. From these it produces four results: the low bits of the physical address, the 64-bit write data shifted into the right lanes, a byte-count field and an 8-bit byte-enable vector for the memory.

The block computes a byte offset inside the access and, for a left store, a word index. The data shift, the number of bytes written and the lane placement all follow from these two values. A left store writes the high-order part of the register and a right store writes the low-order part. Together, a left/right pair covers any unaligned location. Results appear in the same cycle as the valid input. Address translation, the memory itself and any write buffering are outside the block.

Top module: `pstore_aligner`

## Requirements
- R1: For a left store whose word index is 0, the byte offset is b = (a XOR m) AND acc. Here a is the low three address bits, m is 7 when cpu_big=1 and 0 otherwise, and acc is 3 for a word (is_dword=0) or 7 for a doubleword (is_dword=1). The block drives byte_cnt = b and wr_data = src_data shifted right by 8*acc - 8*b bits.
- R2: For a left word store (is_dword=0), bit 2 of (a XOR m) is the word index. When it is 1, wr_data = src_data shifted left by 8*b + 8 bits, and byte_cnt is still b. A doubleword left store always has word index 0.
- R3: For a right store (is_right=1), the offset is r = a XOR m over all three bits. The block drives wr_data = src_data shifted left by 8*r bits and byte_cnt = acc - (acc AND r).
- R4: paddr_lo starts as a XOR 7 when rev_endian=1, or as a when rev_endian=0. The acc bits are then cleared in two cases: a left store with mem_big=0, and a right store with mem_big=1.
- R5: With mem_big=0, byte_en has ones on lanes paddr_lo through paddr_lo+byte_cnt. Lane i is wr_data[8i+7:8i]. Lanes above 7 are dropped.
- R6: With mem_big=1, byte_en has ones on lanes 7-paddr_lo down to 7-paddr_lo-byte_cnt. Lanes below 0 are dropped.
- R7: out_valid equals in_valid in the same cycle. byte_en is all zeros whenever in_valid=0.
- R8: Only the three low bits of eff_addr affect any output.
- R9: In every configuration where the endianness controls agree, the enabled lanes carry consecutive source bytes, in ascending lane order. The agreeing configurations are cpu_big equal to mem_big with rev_endian=0, or cpu_big different from mem_big with rev_endian=1. The first byte is source byte acc-byte_cnt for a left store and source byte 0 for a right store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | Request present |
| eff_addr | input | 32 | Effective byte address |
| is_dword | input | 1 | 1 = doubleword access, 0 = word access |
| is_right | input | 1 | 1 = right partial store, 0 = left partial store |
| cpu_big | input | 1 | 1 = processor runs big-endian |
| mem_big | input | 1 | 1 = memory bus is big-endian |
| rev_endian | input | 1 | 1 = reverse-endian mode active |
| src_data | input | 64 | Source register value |
| out_valid | output | 1 | Result present |
| paddr_lo | output | 3 | Adjusted physical address low bits |
| wr_data | output | 64 | Shifted write data |
| byte_cnt | output | 3 | Bytes written minus one |
| byte_en | output | 8 | Byte-lane write enables |

## Verification
The span assertion, which expects exactly byte_cnt+1 enabled lanes, applies only when the run of lanes fits inside the bus. Clipping happens only when the endianness controls disagree, so the sweep drives just the four agreeing combinations and checks lane contents only there. The right-store assertion takes for granted that the computed offset indexes a lane that exists, which holds because the offset is a three-bit value. Every input combination that the assertions depend on is a static level held while the outputs are sampled, so no glitching input reaches them.

// File: rtl/psa_pkg.sv
package psa_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } psa_side_e;

  // number of bits in n bytes
  function automatic int unsigned bytes_to_bits(int unsigned n);
    return n * BYTE_W;
  endfunction
endpackage

// File: rtl/psa_offset_calc.sv
module psa_offset_calc
  import psa_pkg::*;
#(
  parameter int LANES = 8,
  parameter int OFF_W = $clog2(LANES),
  parameter int SH_W  = $clog2(LANES * BYTE_W) + 1
) (
  input  logic [OFF_W-1:0] addr_lo,
  input  logic             is_dword,
  input  psa_side_e        side,
  input  logic             cpu_big,
  input  logic             mem_big,
  input  logic             rev_endian,
  output logic [OFF_W-1:0] rsh_bytes,
  output logic             word_hi,
  output logic [SH_W-1:0]  up_bits,
  output logic [SH_W-1:0]  lo_bits,
  output logic [OFF_W-1:0] paddr_lo,
  output logic [OFF_W-1:0] byte_cnt
);
  localparam logic [OFF_W-1:0] FULL_MASK = OFF_W'(LANES - 1);
  localparam logic [OFF_W-1:0] HALF_MASK = OFF_W'(LANES / 2 - 1);

  logic [OFF_W-1:0] acc;
  logic [OFF_W-1:0] xa;
  logic [OFF_W-1:0] left_byte;
  logic [OFF_W-1:0] addr_rev;
  logic             clr_acc;

  assign acc       = is_dword ? FULL_MASK : HALF_MASK;
  assign xa        = addr_lo ^ (cpu_big ? FULL_MASK : '0);
  assign left_byte = xa & acc;
  assign word_hi   = |(xa & FULL_MASK & ~acc);
  assign rsh_bytes = xa;

  assign up_bits = SH_W'(bytes_to_bits(32'(left_byte) + 1));
  assign lo_bits = SH_W'(bytes_to_bits(32'(acc) - 32'(left_byte)));

  assign byte_cnt = (side == SIDE_RIGHT) ? (acc - (acc & xa)) : left_byte;

  assign addr_rev = addr_lo ^ (rev_endian ? FULL_MASK : '0);
  assign clr_acc  = (side == SIDE_RIGHT) ? mem_big : ~mem_big;
  assign paddr_lo = clr_acc ? (addr_rev & ~acc) : addr_rev;

  always_comb begin
    AST_CNT_RANGE: assert (byte_cnt <= acc); // R3
    if (side == SIDE_LEFT && !mem_big)
      AST_LEFT_ALIGN: assert ((paddr_lo & acc) == '0); // R4
    if (side == SIDE_RIGHT && mem_big)
      AST_RIGHT_ALIGN: assert ((paddr_lo & acc) == '0); // R4
  end
endmodule

// File: rtl/psa_data_shift.sv
module psa_data_shift
  import psa_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int OFF_W  = $clog2(DATA_W / BYTE_W),
  parameter int SH_W   = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] src_data,
  input  psa_side_e         side,
  input  logic              word_hi,
  input  logic [SH_W-1:0]   up_bits,
  input  logic [SH_W-1:0]   lo_bits,
  input  logic [OFF_W-1:0]  rsh_bytes,
  output logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] left_data;
  logic [DATA_W-1:0] right_data;

  assign left_data  = word_hi ? (src_data << up_bits) : (src_data >> lo_bits);
  assign right_data = src_data << {rsh_bytes, 3'b000};
  assign wr_data    = (side == SIDE_RIGHT) ? right_data : left_data;

  always_comb begin
    if (side == SIDE_RIGHT)
      AST_RIGHT_BASE: assert (wr_data[{rsh_bytes, 3'b000} +: BYTE_W] == src_data[BYTE_W-1:0]); // R3
  end
endmodule

// File: rtl/psa_strobe_gen.sv
module psa_strobe_gen #(
  parameter int LANES = 8,
  parameter int OFF_W = $clog2(LANES)
) (
  input  logic             in_valid,
  input  logic             mem_big,
  input  logic [OFF_W-1:0] paddr_lo,
  input  logic [OFF_W-1:0] byte_cnt,
  output logic [LANES-1:0] byte_en
);
  logic [LANES:0]   run_wide;
  logic [LANES-1:0] run;
  logic [LANES-1:0] le_en;
  logic [LANES-1:0] be_en;
  logic             fits;

  assign run_wide = ((LANES + 1)'(1) << ({1'b0, byte_cnt} + (OFF_W + 1)'(1))) - (LANES + 1)'(1);
  assign run      = run_wide[LANES-1:0];
  assign le_en    = run << paddr_lo;
  assign fits     = ({1'b0, paddr_lo} + {1'b0, byte_cnt}) <= (OFF_W + 1)'(LANES - 1);

  for (genvar i = 0; i < LANES; i++) begin : g_rev
    assign be_en[i] = le_en[LANES-1-i];
  end

  assign byte_en = in_valid ? (mem_big ? be_en : le_en) : '0;

  always_comb begin
    if (!in_valid)
      AST_BE_IDLE: assert (byte_en == '0); // R7
    if (in_valid && fits)
      AST_BE_SPAN: assert ($countones(byte_en) == int'(byte_cnt) + 1); // R5
  end
endmodule

// File: rtl/pstore_aligner.sv
module pstore_aligner
  import psa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int LANES  = DATA_W / BYTE_W,
  parameter int OFF_W  = $clog2(LANES)
) (
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic              is_dword,
  input  logic              is_right,
  input  logic              cpu_big,
  input  logic              mem_big,
  input  logic              rev_endian,
  input  logic [DATA_W-1:0] src_data,
  output logic              out_valid,
  output logic [OFF_W-1:0]  paddr_lo,
  output logic [DATA_W-1:0] wr_data,
  output logic [OFF_W-1:0]  byte_cnt,
  output logic [LANES-1:0]  byte_en
);
  localparam int SH_W = $clog2(DATA_W) + 1;

  psa_side_e        side;
  logic [OFF_W-1:0] rsh_bytes;
  logic             word_hi;
  logic [SH_W-1:0]  up_bits;
  logic [SH_W-1:0]  lo_bits;
  logic             unused_addr_hi;

  assign side           = is_right ? SIDE_RIGHT : SIDE_LEFT;
  assign unused_addr_hi = ^eff_addr[ADDR_W-1:OFF_W];
  assign out_valid      = in_valid;

  psa_offset_calc #(.LANES(LANES), .OFF_W(OFF_W), .SH_W(SH_W)) u_offs (
    .addr_lo    (eff_addr[OFF_W-1:0]),
    .is_dword   (is_dword),
    .side       (side),
    .cpu_big    (cpu_big),
    .mem_big    (mem_big),
    .rev_endian (rev_endian),
    .rsh_bytes  (rsh_bytes),
    .word_hi    (word_hi),
    .up_bits    (up_bits),
    .lo_bits    (lo_bits),
    .paddr_lo   (paddr_lo),
    .byte_cnt   (byte_cnt)
  );

  psa_data_shift #(.DATA_W(DATA_W), .OFF_W(OFF_W), .SH_W(SH_W)) u_shift (
    .src_data  (src_data),
    .side      (side),
    .word_hi   (word_hi),
    .up_bits   (up_bits),
    .lo_bits   (lo_bits),
    .rsh_bytes (rsh_bytes),
    .wr_data   (wr_data)
  );

  psa_strobe_gen #(.LANES(LANES), .OFF_W(OFF_W)) u_strb (
    .in_valid (in_valid),
    .mem_big  (mem_big),
    .paddr_lo (paddr_lo),
    .byte_cnt (byte_cnt),
    .byte_en  (byte_en)
  );

  always_comb begin
    AST_VALID_PASS: assert (out_valid == in_valid); // R7
  end
endmodule

// File: tb/pstore_aligner_tb_top.sv
`timescale 1ns/1ps
module pstore_aligner_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] eff_addr = '0;
  logic        is_dword = 1'b0;
  logic        is_right = 1'b0;
  logic        cpu_big = 1'b0;
  logic        mem_big = 1'b0;
  logic        rev_endian = 1'b0;
  logic [63:0] src_data = '0;
  logic        out_valid;
  logic [2:0]  paddr_lo;
  logic [63:0] wr_data;
  logic [2:0]  byte_cnt;
  logic [7:0]  byte_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [63:0] SRC = 64'h8877_6655_4433_2211;

  always #2 clk = ~clk;

  pstore_aligner dut_i (
    .in_valid(in_valid), .eff_addr(eff_addr), .is_dword(is_dword), .is_right(is_right),
    .cpu_big(cpu_big), .mem_big(mem_big), .rev_endian(rev_endian), .src_data(src_data),
    .out_valid(out_valid), .paddr_lo(paddr_lo), .wr_data(wr_data), .byte_cnt(byte_cnt),
    .byte_en(byte_en)
  );

  typedef struct packed {
    logic        right;
    logic        dword;
    logic        cpu;
    logic        mem;
    logic        rev;
    logic [2:0]  a;
    logic [2:0]  paddr;
    logic [2:0]  cnt;
    logic [7:0]  be;
    logic [63:0] data;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 3'd0, 3'd1, 8'h03, 64'h0000_0000_0000_4433},
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 3'd1, 3'd2, 8'h0E, 64'h0000_0000_3322_1100},
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd1, 3'd1, 3'd2, 8'h70, 64'h0044_3322_0000_0000},
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3'd1, 3'd0, 3'd1, 8'hC0, 64'h2211_0000_0000_0000},
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 3'd0, 8'h01, 64'h0000_0000_0000_0088},
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd7, 3'd7, 3'd0, 8'h80, 64'h1100_0000_0000_0000},
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd7, 3'd0, 3'd7, 8'hFF, 64'h8877_6655_4433_2211},
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 3'd6, 3'd1, 8'h03, 64'h0000_0000_0000_4433},
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd5, 3'd4, 3'd1, 8'h30, 64'h0000_4433_0000_0000}
  };

  function automatic logic [63:0] lane_mask(logic [7:0] be);
    logic [63:0] m = '0;
    for (int i = 0; i < 8; i++) if (be[i]) m[8*i +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [31:0] addr, logic dw, logic rt, logic cb,
                       logic mb, logic rv, logic [63:0] d);
    @(posedge clk);
    #0.5;
    in_valid = v; eff_addr = addr; is_dword = dw; is_right = rt;
    cpu_big = cb; mem_big = mb; rev_endian = rv; src_data = d;
    @(negedge clk);
  endtask

  // independent model: counts and lanes, then byte placement per R9
  task automatic model(logic [2:0] a, logic dw, logic rt, logic cb, logic mb, logic rv,
                       logic [63:0] d, output logic [2:0] e_p, output logic [2:0] e_c,
                       output logic [7:0] e_be, output logic [63:0] e_d);
    int acc = dw ? 7 : 3;
    int x = int'(a) ^ (cb ? 7 : 0);
    int p = int'(a) ^ (rv ? 7 : 0);
    int n;
    int k;
    int first;
    if ((rt && mb) || (!rt && !mb)) p = p & ~acc;
    if (rt) n = acc + 1 - (x & acc);
    else    n = (x & acc) + 1;
    e_p = 3'(p);
    e_c = 3'(n - 1);
    e_be = '0;
    for (int i = 0; i < n; i++) begin
      int ln = mb ? (7 - p - i) : (p + i);
      if (ln >= 0 && ln < 8) e_be[ln] = 1'b1;
    end
    first = rt ? 0 : acc - (n - 1);
    e_d = '0;
    k = first;
    for (int ln = 0; ln < 8; ln++) begin
      if (e_be[ln]) begin
        e_d[8*ln +: 8] = d[8*k +: 8];
        k++;
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [2:0]  e_p;
    logic [2:0]  e_c;
    logic [7:0]  e_be;
    logic [63:0] e_d;
    logic [63:0] dsave;
    logic [7:0]  besave;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7 reset state: nothing requested
    check(out_valid == 1'b0 && byte_en == 8'h00, "R7 reset", {out_valid, byte_en}, 0);
    rst_n = 1'b1;

    // vector table: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < NVEC; v++) begin
      vec_t t = VECS[v];
      drive(1'b1, {29'd0, t.a}, t.dword, t.right, t.cpu, t.mem, t.rev, SRC);
      check(paddr_lo == t.paddr, "R4 table paddr", paddr_lo, t.paddr);
      check(byte_cnt == t.cnt, t.right ? "R3 table cnt" : "R1 table cnt", byte_cnt, t.cnt);
      check(byte_en == t.be, t.mem ? "R6 table be" : "R5 table be", byte_en, t.be);
      check((wr_data & lane_mask(t.be)) == t.data, (v == 8 || v == 2) ? "R2 table data" : "R1/R3 table data",
            wr_data & lane_mask(t.be), t.data);
      check(out_valid == 1'b1, "R7 table valid", out_valid, 1);
    end

    // sweep of agreeing configurations: R9 R5 R6
    for (int cfg = 0; cfg < 4; cfg++) begin
      logic cb = cfg[0];
      logic rv = cfg[1];
      logic mb = cb ^ rv;
      for (int dw = 0; dw < 2; dw++) begin
        for (int rt = 0; rt < 2; rt++) begin
          for (int a = 0; a < 8; a++) begin
            drive(1'b1, 32'(a), dw[0], rt[0], cb, mb, rv, SRC);
            model(3'(a), dw[0], rt[0], cb, mb, rv, SRC, e_p, e_c, e_be, e_d);
            check({paddr_lo, byte_cnt, byte_en} == {e_p, e_c, e_be},
                  mb ? "R6 sweep ctl" : "R5 sweep ctl",
                  {paddr_lo, byte_cnt, byte_en}, {e_p, e_c, e_be});
            check((wr_data & lane_mask(e_be)) == e_d, "R9 sweep data",
                  wr_data & lane_mask(e_be), e_d);
          end
        end
      end
    end

    // R8: high address bits have no effect
    drive(1'b1, 32'h0000_0001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, SRC);
    dsave = wr_data; besave = byte_en;
    drive(1'b1, 32'hFFFF_FFF9, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, SRC);
    check(wr_data == dsave && byte_en == besave && paddr_lo == 3'd1, "R8 high bits",
          {wr_data, byte_en}, {dsave, besave});

    // R7: valid low gives no strobe even with a live request pattern
    drive(1'b0, 32'h0000_0003, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, SRC);
    check(out_valid == 1'b0 && byte_en == 8'h00, "R7 idle", {out_valid, byte_en}, 0);

    // R2: doubleword left never uses the high-word path (a=4, LE)
    drive(1'b1, 32'h0000_0004, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, SRC);
    check((wr_data & 64'h0000_00FF_FFFF_FFFF) == (SRC >> 24) && byte_en == 8'h1F, "R2 dword",
          wr_data & 64'h0000_00FF_FFFF_FFFF, SRC >> 24);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule